// File: doc/BRIEF.md
# Coalescing Store Buffer with Load Forwarding

This block sits between a core's store execution stage and its private data cache. A store is written into the buffer in the cycle it executes, with its word address, data and byte enables. It does not wait for the cache. Pending entries then drain to the cache one at a time, oldest first, over a valid/ready handshake. A cache stall is shown only as `cm_ready` held low. While that stall lasts, the oldest entry and every entry behind it stay in place.

Loads probe the buffer with a word address and a byte mask. Each requested byte comes from the youngest pending store that writes it. If every requested byte is covered, the load gets a full hit. If only some are covered, the load is told to retry. A narrow store that lands in the same aligned 32-bit word as the youngest entry is merged into that entry, so the cache sees one wider write. A fence request is acknowledged only once the buffer has fully drained.

The fence handshake is a three-state machine:

| State | Meaning |
|---|---|
| `FN_IDLE` | No fence is pending. |
| `FN_WAIT` | A fence is pending and stores remain. |
| `FN_DONE` | The fence is acknowledged. |

Its transitions are:

| From | To | Condition |
|---|---|---|
| `FN_IDLE` | `FN_DONE` | Request seen and the buffer will be empty after this edge. |
| `FN_IDLE` | `FN_WAIT` | Request seen and entries remain. |
| `FN_WAIT` | `FN_DONE` | The buffer drains. |
| `FN_WAIT` | `FN_IDLE` | The request is withdrawn. |
| `FN_DONE` | `FN_IDLE` | The request drops. |
| `FN_DONE` | `FN_WAIT` | A new store makes the buffer non-empty while the request is still held. |

Top module: `wrbuf_top`

## Requirements
- R1: With fewer than DEPTH entries held, `st_ready` is high. An accepted store appears on the commit port (`cm_valid` high) in the next cycle, whatever the value of `cm_ready`.
- R2: Entries leave through the commit port in the order their stores were accepted. One entry leaves per cycle in which `cm_valid` and `cm_ready` are both high.
- R3: For a load, each byte i that is set in `ld_be` comes from the youngest pending entry with the same word address and byte-enable bit i set. That byte appears on `ld_data[8i+7:8i]`. `ld_hit` is high when all requested bytes are covered.
- R4: If some, but not all, requested bytes are covered, `ld_retry` is high and `ld_hit` is low. If no requested byte is covered, both are low. `ld_hit` and `ld_retry` are never high together.
- R5: A store whose word address equals that of the youngest entry is merged into it when at least two entries are held. Its enabled bytes overwrite, the byte enables are ORed, and no new entry is taken.
- R6: When exactly one entry is held, it is the one presented for commit. A store to its word then takes a new entry, so the cache sees two separate writes.
- R7: When DEPTH entries are held and no commit or merge happens, `st_ready` is low. A store and a commit in the same cycle are both accepted, and the buffer stays full.
- R8: While `cm_valid` is high and `cm_ready` is low, the commit port payload holds steady and no younger entry is committed.
- R9: `fence_ack` rises only once the buffer is empty and stays low while entries remain. It is high in state `FN_DONE` and returns low after `fence_req` drops.
- R10: After reset the buffer is empty. `cm_valid` and `fence_ack` are low and `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_valid | input | 1 | Executed store present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_waddr | input | 30 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| cm_valid | output | 1 | Oldest entry offered to the cache |
| cm_ready | input | 1 | Cache accepts the offered entry |
| cm_waddr | output | 30 | Commit word address |
| cm_data | output | 32 | Commit data |
| cm_be | output | 4 | Commit byte enables |
| ld_valid | input | 1 | Load probe active |
| ld_waddr | input | 30 | Load word address |
| ld_be | input | 4 | Requested load bytes |
| ld_hit | output | 1 | All requested bytes forwarded |
| ld_retry | output | 1 | Partial coverage, load must retry |
| ld_data | output | 32 | Forwarded bytes, zero where not covered |
| fence_req | input | 1 | Fence request, held until acknowledged |
| fence_ack | output | 1 | Fence satisfied, buffer empty |

## Verification
The bench builds the block with its default DEPTH of 8. Earlier scenarios leave the head and tail pointers at slot 6, so the eight-store fill that follows wraps both pointers past the end of storage. It also reaches the full condition, the simultaneous store-plus-commit case and a full drain.

With depth 8, a handful of overlapping narrow stores fits alongside other traffic. This lets the bench check youngest-wins forwarding and merges against a stalled head.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;

    localparam int WB_AW = 30;
    localparam int WB_DW = 32;
    localparam int WB_NB = WB_DW / 8;

    typedef struct packed {
        logic [WB_AW-1:0] waddr;
        logic [WB_DW-1:0] data;
        logic [WB_NB-1:0] be;
    } wb_ent_t;

    typedef enum logic [1:0] {
        FN_IDLE = 2'd0,
        FN_WAIT = 2'd1,
        FN_DONE = 2'd2
    } fence_st_e;

endpackage

// File: rtl/wrbuf_store.sv
module wrbuf_store
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    st_valid,
    input  wb_ent_t st_ent,
    output logic    st_ready,
    input  logic    cm_ready,
    output logic    cm_valid,
    output wb_ent_t cm_ent,
    output wb_ent_t age_ent [DEPTH],
    output logic    age_vld [DEPTH],
    output logic    drained
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    wb_ent_t        mem [DEPTH];
    logic [PW-1:0]  head, tail, yidx;
    logic [CW-1:0]  count, count_next;
    logic           can_merge, st_fire, cm_fire, alloc;
    wb_ent_t        merged;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        yidx      = (tail == '0) ? PW'(DEPTH - 1) : tail - PW'(1);
        can_merge = (count >= CW'(2)) && (mem[yidx].waddr == st_ent.waddr);
        cm_valid  = (count != '0);
        cm_ent    = mem[head];
        cm_fire   = cm_valid && cm_ready;
        st_ready  = can_merge || (count < CW'(DEPTH)) || cm_ready;
        st_fire   = st_valid && st_ready;
        alloc     = st_fire && !can_merge;
        count_next = count + CW'(alloc) - CW'(cm_fire);
        drained   = (count_next == '0);
        merged    = mem[yidx];
        for (int b = 0; b < WB_NB; b++) begin
            if (st_ent.be[b]) merged.data[8*b +: 8] = st_ent.data[8*b +: 8];
        end
        merged.be = mem[yidx].be | st_ent.be;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (alloc)   tail <= wrap_inc(tail);
            if (cm_fire) head <= wrap_inc(head);
            count <= count_next;
        end
    end

    always_ff @(posedge clk) begin
        if (st_fire) begin
            if (can_merge) mem[yidx] <= merged;
            else           mem[tail] <= st_ent;
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [PW:0] sum;
        always_comb begin
            sum = {1'b0, head} + (PW+1)'(k);
            if (sum >= (PW+1)'(DEPTH)) sum = sum - (PW+1)'(DEPTH);
            age_ent[k] = mem[sum[PW-1:0]];
            age_vld[k] = (CW'(k) < count);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R7
    AST_CM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid && !cm_ready |=> cm_valid && $stable(cm_ent)); // R8
    AST_MERGE_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        st_fire && can_merge && !cm_fire |=> count == $past(count)); // R5
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        count == CW'(DEPTH) && st_fire && cm_fire |=> count == CW'(DEPTH)); // R7
    AST_ACCEPT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_fire |=> cm_valid); // R1

endmodule

// File: rtl/wrbuf_fwd.sv
module wrbuf_fwd
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             ld_valid,
    input  logic [WB_AW-1:0] ld_waddr,
    input  logic [WB_NB-1:0] ld_be,
    input  wb_ent_t          age_ent [DEPTH],
    input  logic             age_vld [DEPTH],
    output logic             ld_hit,
    output logic             ld_retry,
    output logic [WB_DW-1:0] ld_data
);

    logic [WB_NB-1:0] cov;
    logic [WB_NB-1:0] got;

    always_comb begin
        cov     = '0;
        ld_data = '0;
        for (int b = 0; b < WB_NB; b++) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (age_vld[k] && age_ent[k].waddr == ld_waddr && age_ent[k].be[b]) begin
                    cov[b]             = 1'b1;
                    ld_data[8*b +: 8]  = age_ent[k].data[8*b +: 8];
                end
            end
            if (!ld_be[b]) ld_data[8*b +: 8] = '0;
        end
        got      = cov & ld_be;
        ld_hit   = ld_valid && (ld_be != '0) && (got == ld_be);
        ld_retry = ld_valid && (got != '0) && (got != ld_be);
    end

    always_comb begin
        AST_FWD_EXCL: assert (!(ld_hit && ld_retry)); // R4
    end

endmodule

// File: rtl/wrbuf_fence.sv
module wrbuf_fence
    import wrbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fence_req,
    input  logic drained,
    output logic fence_ack
);

    fence_st_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FN_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FN_IDLE: if (fence_req) state_nx = drained ? FN_DONE : FN_WAIT;
            FN_WAIT: begin
                if (!fence_req)   state_nx = FN_IDLE;
                else if (drained) state_nx = FN_DONE;
            end
            FN_DONE: begin
                if (!fence_req)    state_nx = FN_IDLE;
                else if (!drained) state_nx = FN_WAIT;
            end
            default: state_nx = FN_IDLE;
        endcase
    end

    always_comb begin
        fence_ack = (state == FN_DONE);
    end

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fence_ack) |-> $past(fence_req)); // R9

endmodule

// File: rtl/wrbuf_top.sv
module wrbuf_top
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    output logic             st_ready,
    input  logic [WB_AW-1:0] st_waddr,
    input  logic [WB_DW-1:0] st_data,
    input  logic [WB_NB-1:0] st_be,
    output logic             cm_valid,
    input  logic             cm_ready,
    output logic [WB_AW-1:0] cm_waddr,
    output logic [WB_DW-1:0] cm_data,
    output logic [WB_NB-1:0] cm_be,
    input  logic             ld_valid,
    input  logic [WB_AW-1:0] ld_waddr,
    input  logic [WB_NB-1:0] ld_be,
    output logic             ld_hit,
    output logic             ld_retry,
    output logic [WB_DW-1:0] ld_data,
    input  logic             fence_req,
    output logic             fence_ack
);

    wb_ent_t st_ent, cm_ent;
    wb_ent_t age_ent [DEPTH];
    logic    age_vld [DEPTH];
    logic    drained;

    always_comb begin
        st_ent.waddr = st_waddr;
        st_ent.data  = st_data;
        st_ent.be    = st_be;
        cm_waddr     = cm_ent.waddr;
        cm_data      = cm_ent.data;
        cm_be        = cm_ent.be;
    end

    wrbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ent(st_ent), .st_ready(st_ready),
        .cm_ready(cm_ready), .cm_valid(cm_valid), .cm_ent(cm_ent),
        .age_ent(age_ent), .age_vld(age_vld), .drained(drained)
    );

    wrbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
        .ld_valid(ld_valid), .ld_waddr(ld_waddr), .ld_be(ld_be),
        .age_ent(age_ent), .age_vld(age_vld),
        .ld_hit(ld_hit), .ld_retry(ld_retry), .ld_data(ld_data)
    );

    wrbuf_fence u_fence (
        .clk(clk), .rst_n(rst_n),
        .fence_req(fence_req), .drained(drained), .fence_ack(fence_ack)
    );

    AST_FENCE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fence_ack |-> !cm_valid); // R9

endmodule

// File: tb/sim_wrbuf_top.sv
module sim_wrbuf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [29:0] st_waddr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        cm_valid;
    logic        cm_ready = 1'b0;
    logic [29:0] cm_waddr;
    logic [31:0] cm_data;
    logic [3:0]  cm_be;
    logic        ld_valid = 1'b0;
    logic [29:0] ld_waddr = '0;
    logic [3:0]  ld_be = '0;
    logic        ld_hit, ld_retry;
    logic [31:0] ld_data;
    logic        fence_req = 1'b0;
    logic        fence_ack;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wrbuf_top #(.DEPTH(8)) u0 (.*);

    typedef struct packed {
        logic [29:0] a;
        logic [3:0]  be;
        logic        hit;
        logic        rt;
        logic [31:0] d;
    } ld_vec_t;

    localparam ld_vec_t LD_TAB [7] = '{
        '{30'h10, 4'b1111, 1'b1, 1'b0, 32'h55223344},
        '{30'h20, 4'b0011, 1'b1, 1'b0, 32'h0000BBAA},
        '{30'h20, 4'b0111, 1'b0, 1'b1, 32'h0},
        '{30'h30, 4'b1100, 1'b1, 1'b0, 32'hCAFE0000},
        '{30'h30, 4'b0001, 1'b0, 1'b0, 32'h0},
        '{30'h40, 4'b1111, 1'b0, 1'b0, 32'h0},
        '{30'h10, 4'b1000, 1'b1, 1'b0, 32'h55000000}
    };

    function automatic logic [31:0] bmask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [29:0] a, input logic [31:0] d, input logic [3:0] be);
        st_valid = 1'b1; st_waddr = a; st_data = d; st_be = be;
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic take(input logic [29:0] a, input logic [31:0] d, input logic [3:0] be, input string req);
        chk(cm_valid === 1'b1, req, {63'd0, cm_valid}, 64'd1);
        chk(cm_waddr === a && cm_be === be && (cm_data & bmask(be)) === (d & bmask(be)), req,
            {cm_waddr, cm_be, cm_data & bmask(be)}, {a, be, d & bmask(be)});
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_run++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(cm_valid === 1'b0 && fence_ack === 1'b0 && st_ready === 1'b1, "R10",
            {61'd0, cm_valid, fence_ack, st_ready}, 64'd1);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // Fill with cache stalled
        cm_ready = 1'b0;
        push(30'h10, 32'h11223344, 4'b1111);
        chk(cm_valid === 1'b1 && cm_waddr === 30'h10, "R1", {33'd0, cm_valid, cm_waddr}, {33'd0, 1'b1, 30'h10});
        push(30'h20, 32'h000000AA, 4'b0001);
        push(30'h20, 32'h0000BB00, 4'b0010); // R5 merge into youngest
        push(30'h10, 32'h55000000, 4'b1000);
        push(30'h30, 32'hCAFEF00D, 4'b1100);
        repeat (3) @(posedge clk); #1;
        // R8 stalled head blocks
        chk(cm_valid === 1'b1 && cm_waddr === 30'h10 && cm_be === 4'hF, "R8",
            {30'd0, cm_waddr, cm_be}, {30'd0, 30'h10, 4'hF});

        // Forwarding table R3 / R4
        ld_valid = 1'b1;
        for (int i = 0; i < 7; i++) begin
            ld_waddr = LD_TAB[i].a; ld_be = LD_TAB[i].be;
            #1;
            chk(ld_hit === LD_TAB[i].hit && ld_retry === LD_TAB[i].rt, "R3/R4 flags",
                {62'd0, ld_hit, ld_retry}, {62'd0, LD_TAB[i].hit, LD_TAB[i].rt});
            if (LD_TAB[i].hit)
                chk(ld_data === LD_TAB[i].d, "R3 data", {32'd0, ld_data}, {32'd0, LD_TAB[i].d});
        end
        ld_valid = 1'b0;
        #1;
        chk(ld_hit === 1'b0 && ld_retry === 1'b0, "R4 idle", {62'd0, ld_hit, ld_retry}, 64'd0);

        // R9 fence waits while stalled
        fence_req = 1'b1;
        repeat (4) @(posedge clk); #1;
        chk(fence_ack === 1'b0, "R9 wait", {63'd0, fence_ack}, 64'd0);

        // R2 in-order drain, R5 merged single write
        cm_ready = 1'b1;
        take(30'h10, 32'h11223344, 4'b1111, "R2");
        take(30'h20, 32'h0000BBAA, 4'b0011, "R5");
        take(30'h10, 32'h55000000, 4'b1000, "R2");
        take(30'h30, 32'hCAFE0000, 4'b1100, "R2");
        chk(fence_ack === 1'b1 && cm_valid === 1'b0, "R9 ack", {62'd0, fence_ack, cm_valid}, {62'd0, 2'b10});
        fence_req = 1'b0;
        @(posedge clk); #1;
        chk(fence_ack === 1'b0, "R9 drop", {63'd0, fence_ack}, 64'd0);

        // R9 fence on empty buffer
        fence_req = 1'b1;
        @(posedge clk); #1;
        chk(fence_ack === 1'b1, "R9 empty", {63'd0, fence_ack}, 64'd1);
        fence_req = 1'b0;
        @(posedge clk); #1;

        // R6 no merge into the head entry
        cm_ready = 1'b0;
        push(30'h50, 32'h00000001, 4'b0001);
        push(30'h50, 32'h00000200, 4'b0010);
        cm_ready = 1'b1;
        take(30'h50, 32'h00000001, 4'b0001, "R6");
        take(30'h50, 32'h00000200, 4'b0010, "R6");
        chk(cm_valid === 1'b0, "R6 empty", {63'd0, cm_valid}, 64'd0);

        // R7 full buffer with pointer wrap
        cm_ready = 1'b0;
        for (int i = 0; i < 8; i++) push(30'h100 + 30'(i), 32'(i) + 32'hA0, 4'b1111);
        st_valid = 1'b1; st_waddr = 30'h200; st_data = 32'hDEAD0200; st_be = 4'hF;
        #1;
        chk(st_ready === 1'b0, "R7 full", {63'd0, st_ready}, 64'd0);
        cm_ready = 1'b1;
        #1;
        chk(st_ready === 1'b1, "R7 swap", {63'd0, st_ready}, 64'd1);
        @(posedge clk); #1;
        st_valid = 1'b0; st_waddr = 30'h300; cm_ready = 1'b0;
        #1;
        chk(st_ready === 1'b0 && cm_valid === 1'b1, "R7 still full", {62'd0, st_ready, cm_valid}, {62'd0, 2'b01});
        cm_ready = 1'b1;
        for (int i = 1; i < 8; i++) take(30'h100 + 30'(i), 32'(i) + 32'hA0, 4'b1111, "R7");
        take(30'h200, 32'hDEAD0200, 4'hF, "R7");
        chk(cm_valid === 1'b0, "R2 drained", {63'd0, cm_valid}, 64'd0);

        // R10 reset mid-traffic empties buffer
        cm_ready = 1'b0;
        push(30'h77, 32'h12345678, 4'hF);
        fence_req = 1'b1;
        rst_n = 1'b0;
        #1;
        chk(cm_valid === 1'b0 && fence_ack === 1'b0, "R10 reset", {62'd0, cm_valid, fence_ack}, 64'd0);
        fence_req = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule